// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block models a clocked single-port static memory with a 32-bit word split into four byte lanes and a small internal array. On every rising clock edge it decodes one command from three chip selects, a load/advance strobe, a read/write select, four active-low byte write strobes, an output enable, an active-low clock enable and a sleep input. A load cycle either opens a burst at an external address or deselects the part. Advance cycles then step a 2-bit counter that wraps inside an aligned group of four words.

Reads are flow-through. The load or advance edge registers the access address, and the addressed word then appears combinationally on the read bus in the cycle that follows, with a valid flag. When the bus is not driven, the data lines read as zero, which stands in for high impedance. Writes take the write data, byte strobes and address at the same edge as the command. A dummy read (enable off) and a write abort (no strobe active) both open a burst without moving any data. A stalled edge freezes every state bit. In sleep the part ignores its inputs and does not drive the bus.

Top module: `fsb_sram`

## Requirements
- R1: While reset is asserted and after it is released, `rdata_vld` is 0 and `rdata` is 0 until a read command drives the bus.
- R2: With `clk_en_n`=0 and `sleep`=0, an edge with `adv_ld`=0, `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0 and `rd_nwr`=1 opens a read burst at `addr_in`. If `out_en_n` was 0 at that edge, the word at that address is presented with `rdata_vld`=1 after the edge.
- R3: A read load with `out_en_n`=1 leaves `rdata_vld`=0 but still opens the burst. A following advance reads the next word in the burst.
- R4: A load edge with `sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1 is a deselect: no write happens and the bus is not driven. Later advance edges continue the deselect and neither access nor drive.
- R5: Each advance edge (`adv_ld`=1) inside a burst increments address bits 1:0 modulo 4 before the access and leaves the upper address bits unchanged.
- R6: Read or write is fixed by `rd_nwr` at the load edge. `rd_nwr` is ignored on advance edges.
- R7: In a write cycle, `byte_we_n[i]`=0 writes `wdata[8i+7:8i]` (bit 0 to bits 7:0, up to bit 3 to bits 31:24). When all four strobes are 1, the cycle is a write abort: memory is unchanged but the burst still opens or advances.
- R8: The bus is not driven after any write edge, whatever `out_en_n` is.
- R9: An edge with `clk_en_n`=1 holds all state. A bus driven by a read stays driven with the same data, an undriven bus stays undriven, and no write occurs.
- R10: While `sleep`=1, `rdata_vld` is 0. An edge with `sleep`=1 performs no access and changes nothing except the drive state, which goes off. The burst address and type are kept.
- R11: Whenever `rdata_vld` is 0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW (6) | External word address for load cycles |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load a new burst, 1 = advance the current burst |
| rd_nwr | input | 1 | Burst type at load: 1 = read, 0 = write |
| byte_we_n | input | NB (4) | Active-low byte write strobes |
| out_en_n | input | 1 | Active-low output enable for read cycles |
| clk_en_n | input | 1 | Active-low clock enable; 1 stalls the edge |
| sleep | input | 1 | Sleep: no operation, bus off |
| wdata | input | 8*NB (32) | Write data, sampled at the write edge |
| rdata | output | 8*NB (32) | Read data, zero when not driven |
| rdata_vld | output | 1 | Bus driven flag |

## Verification
The hardest situations to reach are those that depend on state from earlier cycles. A stall or sleep inside a burst must keep the burst address. An advance after a deselect must stay inert. An advance must carry on with the type latched at the load even when `rd_nwr` has since flipped. Directed sequences set these up explicitly: a write burst that wraps past address 7, a stalled read, a sleep inside a read burst, a deselect followed by advances carrying write strobes, and a dummy read followed by an advance. A seeded random phase then mixes long advance runs with stalls, sleeps and deselects, and checks every cycle against a bench reference model.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  typedef enum logic [2:0] {
    CMD_SLEEP,
    CMD_STALL,
    CMD_DESEL,
    CMD_CDESEL,
    CMD_RD_BEG,
    CMD_WR_BEG,
    CMD_RD_CONT,
    CMD_WR_CONT
  } fsb_cmd_e;

endpackage

// File: rtl/fsb_decode.sv
module fsb_decode
  import fsb_pkg::*;
(
  input  logic     sleep,
  input  logic     clk_en_n,
  input  logic     adv_ld,
  input  logic     sel_a_n,
  input  logic     sel_b,
  input  logic     sel_c_n,
  input  logic     rd_nwr,
  input  logic     act_q,
  input  logic     rd_q,
  output fsb_cmd_e cmd
);

  logic sel_ok;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  // priority: sleep, then stall, then load/advance
  always_comb begin
    if (sleep)             cmd = CMD_SLEEP;
    else if (clk_en_n)     cmd = CMD_STALL;
    else if (!adv_ld) begin
      if (!sel_ok)         cmd = CMD_DESEL;
      else if (rd_nwr)     cmd = CMD_RD_BEG;
      else                 cmd = CMD_WR_BEG;
    end
    else if (!act_q)       cmd = CMD_CDESEL;
    else if (rd_q)         cmd = CMD_RD_CONT;
    else                   cmd = CMD_WR_CONT;
  end

endmodule

// File: rtl/fsb_addr.sv
module fsb_addr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] acc_addr
);

  // wrap-around increment within an aligned group of four words
  function automatic logic [AW-1:0] wrap_step(input logic [AW-1:0] a);
    logic [1:0] low;
    low = a[1:0] + 2'd1;
    return {a[AW-1:2], low};
  endfunction

  assign acc_addr = load ? addr_in : wrap_step(cur_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cur_addr <= '0;
    else if (load || step) cur_addr <= acc_addr;
  end

endmodule

// File: rtl/fsb_array.sv
module fsb_array #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB-1:0]   be,
  input  logic [AW-1:0]   waddr,
  input  logic [8*NB-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [8*NB-1:0] rword
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
      end else if (be[g]) begin
        lane_mem[waddr] <= wdata[8*g +: 8];
      end
    end

    assign rword[8*g +: 8] = lane_mem[raddr];
  end

endmodule

// File: rtl/fsb_sram.sv
module fsb_sram
  import fsb_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_in,
  input  logic            sel_a_n,
  input  logic            sel_b,
  input  logic            sel_c_n,
  input  logic            adv_ld,
  input  logic            rd_nwr,
  input  logic [NB-1:0]   byte_we_n,
  input  logic            out_en_n,
  input  logic            clk_en_n,
  input  logic            sleep,
  input  logic [8*NB-1:0] wdata,
  output logic [8*NB-1:0] rdata,
  output logic            rdata_vld
);

  localparam int DW = 8 * NB;

  fsb_cmd_e      cmd;
  logic          act_q, rd_q, drive_q;
  logic          load, step, is_wr, wr_fire;
  logic [NB-1:0] be;
  logic [AW-1:0] cur_addr, acc_addr;
  logic [DW-1:0] arr_word;

  fsb_decode u_dec (
    .sleep(sleep), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .rd_nwr(rd_nwr), .act_q(act_q), .rd_q(rd_q), .cmd(cmd)
  );

  assign load    = (cmd == CMD_RD_BEG)  || (cmd == CMD_WR_BEG);
  assign step    = (cmd == CMD_RD_CONT) || (cmd == CMD_WR_CONT);
  assign is_wr   = (cmd == CMD_WR_BEG)  || (cmd == CMD_WR_CONT);
  assign be      = is_wr ? ~byte_we_n : '0;
  assign wr_fire = |be;

  fsb_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .addr_in(addr_in), .cur_addr(cur_addr), .acc_addr(acc_addr)
  );

  fsb_array #(.AW(AW), .NB(NB)) u_arr (
    .clk(clk), .rst_n(rst_n), .be(be), .waddr(acc_addr),
    .wdata(wdata), .raddr(cur_addr), .rword(arr_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      case (cmd)
        CMD_SLEEP:   drive_q <= 1'b0;
        CMD_STALL:   ;
        CMD_DESEL: begin
          act_q   <= 1'b0;
          drive_q <= 1'b0;
        end
        CMD_CDESEL:  drive_q <= 1'b0;
        CMD_RD_BEG: begin
          act_q   <= 1'b1;
          rd_q    <= 1'b1;
          drive_q <= !out_en_n;
        end
        CMD_WR_BEG: begin
          act_q   <= 1'b1;
          rd_q    <= 1'b0;
          drive_q <= 1'b0;
        end
        CMD_RD_CONT: drive_q <= !out_en_n;
        CMD_WR_CONT: drive_q <= 1'b0;
        default:     drive_q <= 1'b0;
      endcase
    end
  end

  assign rdata_vld = drive_q && !sleep;
  assign rdata     = rdata_vld ? arr_word : '0;

endmodule

// File: rtl/fsb_sram_chk.sv
module fsb_sram_chk #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          clk_en_n,
  input logic [AW-1:0] addr_in,
  input logic [DW-1:0] rdata,
  input logic          rdata_vld,
  input logic          drive_q,
  input logic [AW-1:0] cur_addr,
  input logic          load,
  input logic          step,
  input logic          is_wr,
  input logic          wr_fire
);

  p_quiet_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_vld |-> (rdata == '0));

  p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_vld);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !sleep) |=> ($stable(cur_addr) && $stable(drive_q)));

  p_stall_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |-> !wr_fire);

  p_write_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |=> !drive_q);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])) &&
              (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)));

  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_addr == $past(addr_in)));

endmodule

bind fsb_sram fsb_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .clk_en_n(clk_en_n),
  .addr_in(addr_in), .rdata(rdata), .rdata_vld(rdata_vld),
  .drive_q(drive_q), .cur_addr(cur_addr), .load(load), .step(step),
  .is_wr(is_wr), .wr_fire(wr_fire)
);

// File: tb/fsb_sram_test.sv
`timescale 1ns/1ps
module fsb_sram_test;
  localparam int AW = 6, NB = 4, DW = 32, DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr_in;
  logic sel_a_n, sel_b, sel_c_n, adv_ld, rd_nwr, out_en_n, clk_en_n, sleep;
  logic [NB-1:0] byte_we_n;
  logic [DW-1:0] wdata, rdata;
  logic rdata_vld;

  int total = 0, bad = 0;

  fsb_sram #(.AW(AW), .NB(NB)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .adv_ld(adv_ld), .rd_nwr(rd_nwr),
    .byte_we_n(byte_we_n), .out_en_n(out_en_n), .clk_en_n(clk_en_n),
    .sleep(sleep), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  always #10 clk = ~clk;

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_cur = '0;
  logic m_act = 1'b0, m_rd = 1'b0, m_drive = 1'b0;

  function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a);
    return (a & ~AW'(3)) | ((a + AW'(1)) & AW'(3));
  endfunction

  function automatic logic [DW-1:0] ref_merge(input logic [DW-1:0] old,
      input logic [DW-1:0] nw, input logic [NB-1:0] stb_n);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++)
      if (!stb_n[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic model_step();
    if (sleep) m_drive = 1'b0;
    else if (clk_en_n) ;
    else if (!adv_ld) begin
      if (!sel_a_n && sel_b && !sel_c_n) begin
        m_cur = addr_in; m_act = 1'b1; m_rd = rd_nwr;
        if (rd_nwr) m_drive = !out_en_n;
        else begin
          m_drive = 1'b0;
          m_mem[m_cur] = ref_merge(m_mem[m_cur], wdata, byte_we_n);
        end
      end else begin
        m_act = 1'b0; m_drive = 1'b0;
      end
    end else if (m_act) begin
      m_cur = ref_next(m_cur);
      if (m_rd) m_drive = !out_en_n;
      else begin
        m_drive = 1'b0;
        m_mem[m_cur] = ref_merge(m_mem[m_cur], wdata, byte_we_n);
      end
    end else m_drive = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic ev;
    @(posedge clk);
    model_step();
    @(negedge clk);
    ev = m_drive && !sleep;
    chk(tag, {rdata_vld, rdata}, {ev, ev ? m_mem[m_cur] : DW'(0)});
  endtask

  task automatic idle();
    addr_in = '0; sel_a_n = 0; sel_b = 1; sel_c_n = 0; adv_ld = 1; rd_nwr = 1;
    byte_we_n = '1; out_en_n = 0; clk_en_n = 0; sleep = 0; wdata = '0;
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic rw,
      input logic [NB-1:0] stb, input logic oe, input logic [DW-1:0] d, input string tag);
    idle(); adv_ld = 0; addr_in = a; rd_nwr = rw; byte_we_n = stb; out_en_n = oe; wdata = d;
    cyc(tag);
  endtask

  task automatic adv(input logic rw, input logic [NB-1:0] stb, input logic oe,
      input logic [DW-1:0] d, input string tag);
    idle(); rd_nwr = rw; byte_we_n = stb; out_en_n = oe; wdata = d;
    cyc(tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    chk("R1 in reset", {rdata_vld, rdata}, '0);
    rst_n = 1;
    cyc("R1 after reset");

    // R7 full writes, R5 wrap past address 7
    ld(6'd5, 0, 4'b0000, 0, 32'hA1B2C3D4, "R7 write load");
    adv(0, 4'b0000, 0, 32'h11111111, "R5 write adv");
    adv(0, 4'b0000, 0, 32'h22222222, "R5 write adv");
    adv(0, 4'b0000, 0, 32'h33333333, "R5 write wrap R8");
    // R2 read, R6 rd_nwr ignored on advance
    ld(6'd6, 1, 4'b1111, 0, 0, "R2 read load");
    adv(0, 4'b0000, 0, 32'hDEADBEEF, "R6 read adv ignores rd_nwr");
    adv(1, 4'b1111, 0, 0, "R5 read wrap");
    // R9 stall during read keeps data
    idle(); clk_en_n = 1; adv_ld = 0; rd_nwr = 0; byte_we_n = 4'b0000; cyc("R9 stall read");
    idle(); clk_en_n = 1; cyc("R9 stall read again");
    adv(1, 4'b1111, 0, 0, "R9 resume");
    // R3 dummy read
    ld(6'd4, 1, 4'b1111, 1, 0, "R3 dummy read");
    adv(1, 4'b1111, 0, 0, "R3 advance after dummy");
    // R7 partial strobes, R8 output off with oe low
    ld(6'd8, 0, 4'b1010, 0, 32'hCAFEF00D, "R7 partial R8");
    adv(0, 4'b0101, 0, 32'h99887766, "R7 partial adv");
    ld(6'd8, 1, 4'b1111, 0, 0, "R7 readback");
    adv(1, 4'b1111, 0, 0, "R7 readback adv");
    // R7 write abort
    ld(6'd12, 0, 4'b1111, 0, 32'hFFFFFFFF, "R7 abort load");
    adv(0, 4'b0000, 0, 32'h12345678, "R7 abort then write");
    ld(6'd12, 1, 4'b1111, 0, 0, "R7 abort readback");
    adv(1, 4'b1111, 0, 0, "R7 abort readback adv");
    // R4 deselect with write strobes, then continue deselect
    idle(); adv_ld = 0; sel_b = 0; rd_nwr = 0; byte_we_n = 0; addr_in = 6'd20; wdata = 32'h55; cyc("R4 deselect");
    adv(0, 4'b0000, 0, 32'h66, "R4 continue deselect");
    idle(); adv_ld = 0; sel_a_n = 1; rd_nwr = 1; addr_in = 6'd21; cyc("R4 deselect a");
    idle(); adv_ld = 0; sel_c_n = 1; rd_nwr = 1; addr_in = 6'd22; cyc("R4 deselect c");
    ld(6'd20, 1, 4'b1111, 0, 0, "R4 readback");
    adv(1, 4'b1111, 0, 0, "R4 readback adv");
    // R10 sleep inside a read burst
    idle(); sleep = 1; adv_ld = 0; rd_nwr = 0; byte_we_n = 0; addr_in = 6'd0; cyc("R10 sleep");
    idle(); sleep = 1; cyc("R10 sleep hold");
    adv(1, 4'b1111, 0, 0, "R10 resume burst");
    // R9 stall during write
    ld(6'd32, 0, 4'b0000, 0, 32'h0BADF00D, "R9 write load");
    idle(); clk_en_n = 1; byte_we_n = 0; wdata = 32'h77777777; cyc("R9 stall write");
    ld(6'd32, 1, 4'b1111, 0, 0, "R9 write readback");
    adv(1, 4'b1111, 0, 0, "R9 stalled word untouched");

    // random phase
    void'($urandom(32'h1F2E3D4C));
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      r = $urandom % 100;
      adv_ld    = (r < 60);
      addr_in   = AW'($urandom);
      rd_nwr    = $urandom % 2;
      byte_we_n = NB'($urandom);
      out_en_n  = ($urandom % 5) == 0;
      wdata     = $urandom;
      sel_a_n   = ($urandom % 10) == 0;
      sel_b     = ($urandom % 10) != 0;
      sel_c_n   = ($urandom % 10) == 0;
      clk_en_n  = ($urandom % 10) == 0;
      sleep     = ($urandom % 20) == 0;
      cyc("R2 R11 random");
    end
    summary();
  end

endmodule